// File: doc/BRIEF.md
# LCD Panel Serial Configuration Sequencer

This block configures an LCD panel over its three-wire serial setup port and needs no processor. A one-cycle request makes it play one of two built-in register tables. The power-up table holds nine writes. The shutdown table holds one write. Each write is one 16-bit frame framed by an active-low select line. The panel takes data on the rising edge of the serial clock.

Every guard time is a whole number of microseconds. A delay counter turns it into system clock cycles through the parameter `CLKS_PER_US`. While a table is running the block raises `busy_o` and ignores new requests. It pulses `done_o` for one cycle when the last frame and its trailing gap are finished. A panel-enable output rises before the first power-up frame is sent. It falls only once the shutdown write has finished.

Top module: `lcd_cfg_seq`

## Requirements
- R1: Each frame is 16 bits wide, sent most significant bit first: the register address in bits 15:8 and the value in bits 7:0. The panel takes each bit on a rising `ser_clk_o` edge while `ser_sel_n_o` is low.
- R2: A frame begins when `ser_sel_n_o` falls while `ser_clk_o` is high and `ser_dat_o` is low. The first falling edge of `ser_clk_o` comes exactly 25 us (25*CLKS_PER_US cycles) later.
- R3: For each bit, `ser_clk_o` is low for exactly 25 us and then high for exactly 25 us. While `ser_sel_n_o` is low, `ser_dat_o` changes only on a falling edge of `ser_clk_o`.
- R4: After the 16th rising edge of `ser_clk_o`, `ser_sel_n_o` returns high 25 us later. It then stays high for at least 100 us before the next frame begins.
- R5: The power-up table first waits at least 50 us after the request is accepted. It then sends, in this order (address/value): 05/16, 04/0B, 07/8D, 01/95, 08/C0, 03/40, 06/75, 13/01, 05/57.
- R6: The shutdown table is a single frame, address 05 with value 5E.
- R7: `panel_on_o` rises in the cycle after a power-up request is accepted, before any frame is sent. It falls only in the same cycle that `done_o` marks the end of the shutdown table.
- R8: During reset and whenever the block is idle, `ser_sel_n_o` and `ser_clk_o` are high and `ser_dat_o` is low. After reset, `busy_o`, `done_o` and `panel_on_o` are low.
- R9: `busy_o` rises in the cycle after a request is accepted. It stays high until the last frame's trailing gap has ended. At that point it falls in the same cycle as a single-cycle pulse on `done_o`.
- R10: Requests that arrive while `busy_o` is high have no effect: no extra frame is sent and `busy_o` does not restart.
- R11: If both request pulses arrive in the same idle cycle, the shutdown table runs and the power-up request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req_i | input | 1 | One-cycle request to run the power-up table |
| off_req_i | input | 1 | One-cycle request to run the shutdown table |
| ser_sel_n_o | output | 1 | Serial port select, active low |
| ser_clk_o | output | 1 | Serial port clock; the panel samples on its rising edge |
| ser_dat_o | output | 1 | Serial port data |
| panel_on_o | output | 1 | Panel display-enable |
| busy_o | output | 1 | A table is running |
| done_o | output | 1 | One-cycle pulse when a table finishes |

## Verification
The hardest cases to reach are the requests that must be ignored: pulses that land in the middle of a long, slowly clocked table. Another is the same-cycle collision of both requests while idle. The bench fires extra power-up and shutdown pulses hundreds of cycles into a running power-up table. It then checks that the scoreboard receives exactly the nine expected frames and that the port stays quiet afterwards. Next, it raises both request lines in the same idle cycle and expects exactly one shutdown frame and no change on `panel_on_o`. A pin monitor decodes every frame cycle by cycle and measures each lead, half-bit and gap time against the microsecond parameters.

// File: rtl/lcd_cfg_pkg.sv
package lcd_cfg_pkg;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned VAL_W     = 8;
  localparam int unsigned FRAME_W   = ADDR_W + VAL_W;
  localparam int unsigned UP_LEN    = 9;
  localparam int unsigned ROM_DEPTH = UP_LEN + 1;
  localparam int unsigned DOWN_IDX  = UP_LEN;
  localparam int unsigned IDX_W     = $clog2(ROM_DEPTH);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [IDX_W-1:0]   idx_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_GAP
  } shift_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_PRE, SQ_SEND, SQ_WAIT
  } seq_state_e;

  // Power-up writes occupy entries 0..UP_LEN-1, the shutdown write follows.
  function automatic frame_t table_entry(input idx_t idx);
    frame_t f;
    case (idx)
      idx_t'(0): f = {8'h05, 8'h16};
      idx_t'(1): f = {8'h04, 8'h0b};
      idx_t'(2): f = {8'h07, 8'h8d};
      idx_t'(3): f = {8'h01, 8'h95};
      idx_t'(4): f = {8'h08, 8'hc0};
      idx_t'(5): f = {8'h03, 8'h40};
      idx_t'(6): f = {8'h06, 8'h75};
      idx_t'(7): f = {8'h13, 8'h01};
      idx_t'(8): f = {8'h05, 8'h57};
      idx_t'(9): f = {8'h05, 8'h5e};
      default:   f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/lcd_cfg_delay.sv
module lcd_cfg_delay #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // Loading value N makes expire_o high N cycles later, one cycle long.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign expire_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/lcd_cfg_serializer.sv
module lcd_cfg_serializer
  import lcd_cfg_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned LEAD_US     = 25,
  parameter int unsigned HALF_US     = 25,
  parameter int unsigned GAP_US      = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go_i,
  input  frame_t frame_i,
  output logic   ready_o,
  output logic   frame_done_o,
  output logic   sel_n_o,
  output logic   sclk_o,
  output logic   sdat_o
);

  localparam int unsigned LEAD_CYC = LEAD_US * CLKS_PER_US;
  localparam int unsigned HALF_CYC = HALF_US * CLKS_PER_US;
  localparam int unsigned GAP_CYC  = GAP_US * CLKS_PER_US;
  localparam int unsigned MAX_LH   = (LEAD_CYC > HALF_CYC) ? LEAD_CYC : HALF_CYC;
  localparam int unsigned MAX_CYC  = (MAX_LH > GAP_CYC) ? MAX_LH : GAP_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned BIT_W    = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  shift_state_e     state_q;
  frame_t           shreg_q;
  logic [BIT_W-1:0] bit_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_exp;

  lcd_cfg_delay #(.CNT_W(CNT_W)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_exp)
  );

  // Each phase reloads the counter with the length of the phase it enters.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(HALF_CYC - 1);
    case (state_q)
      SH_IDLE: begin
        tmr_load = go_i;
        tmr_val  = CNT_W'(LEAD_CYC - 1);
      end
      SH_LEAD, SH_LOW: tmr_load = tmr_exp;
      SH_HIGH: begin
        tmr_load = tmr_exp;
        if (bit_q == LAST_BIT) tmr_val = CNT_W'(GAP_CYC - 1);
      end
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SH_IDLE;
      shreg_q      <= '0;
      bit_q        <= '0;
      sel_n_o      <= 1'b1;
      sclk_o       <= 1'b1;
      sdat_o       <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      case (state_q)
        SH_IDLE: if (go_i) begin
          shreg_q <= frame_i;
          bit_q   <= '0;
          sel_n_o <= 1'b0;
          state_q <= SH_LEAD;
        end
        SH_LEAD: if (tmr_exp) begin
          sclk_o  <= 1'b0;
          sdat_o  <= shreg_q[FRAME_W-1];
          shreg_q <= shreg_q << 1;
          state_q <= SH_LOW;
        end
        SH_LOW: if (tmr_exp) begin
          sclk_o  <= 1'b1;
          state_q <= SH_HIGH;
        end
        SH_HIGH: if (tmr_exp) begin
          if (bit_q == LAST_BIT) begin
            sel_n_o <= 1'b1;
            sdat_o  <= 1'b0;
            state_q <= SH_GAP;
          end else begin
            bit_q   <= bit_q + 1'b1;
            sclk_o  <= 1'b0;
            sdat_o  <= shreg_q[FRAME_W-1];
            shreg_q <= shreg_q << 1;
            state_q <= SH_LOW;
          end
        end
        SH_GAP: if (tmr_exp) begin
          frame_done_o <= 1'b1;
          state_q      <= SH_IDLE;
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == SH_IDLE);

endmodule

// File: rtl/lcd_cfg_sequencer.sv
module lcd_cfg_sequencer
  import lcd_cfg_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned PRE_US      = 50
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   on_req_i,
  input  logic   off_req_i,
  input  logic   ser_ready_i,
  input  logic   frame_done_i,
  output logic   go_o,
  output frame_t frame_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   panel_on_o
);

  localparam int unsigned PRE_CYC = PRE_US * CLKS_PER_US;
  localparam int unsigned CNT_W   = $clog2(PRE_CYC + 1);

  seq_state_e state_q;
  idx_t       idx_q;
  idx_t       last_q;
  logic       down_q;
  logic       pre_load;
  logic       pre_exp;

  // The shutdown request wins a same-cycle collision.
  assign pre_load = (state_q == SQ_IDLE) && on_req_i && !off_req_i;

  lcd_cfg_delay #(.CNT_W(CNT_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .load_i     (pre_load),
    .load_val_i (CNT_W'(PRE_CYC - 1)),
    .expire_o   (pre_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      idx_q      <= '0;
      last_q     <= '0;
      down_q     <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      panel_on_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (off_req_i) begin
            idx_q   <= idx_t'(DOWN_IDX);
            last_q  <= idx_t'(DOWN_IDX);
            down_q  <= 1'b1;
            busy_o  <= 1'b1;
            state_q <= SQ_SEND;
          end else if (on_req_i) begin
            idx_q      <= '0;
            last_q     <= idx_t'(UP_LEN - 1);
            down_q     <= 1'b0;
            busy_o     <= 1'b1;
            panel_on_o <= 1'b1;
            state_q    <= SQ_PRE;
          end
        end
        SQ_PRE:  if (pre_exp) state_q <= SQ_SEND;
        SQ_SEND: if (ser_ready_i) state_q <= SQ_WAIT;
        SQ_WAIT: if (frame_done_i) begin
          if (idx_q == last_q) begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= SQ_IDLE;
            if (down_q) panel_on_o <= 1'b0;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SQ_SEND;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign go_o    = (state_q == SQ_SEND) && ser_ready_i;
  assign frame_o = table_entry(idx_q);

endmodule

// File: rtl/lcd_cfg_seq.sv
module lcd_cfg_seq
  import lcd_cfg_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned PRE_US      = 50,
  parameter int unsigned LEAD_US     = 25,
  parameter int unsigned HALF_US     = 25,
  parameter int unsigned GAP_US      = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic on_req_i,
  input  logic off_req_i,
  output logic ser_sel_n_o,
  output logic ser_clk_o,
  output logic ser_dat_o,
  output logic panel_on_o,
  output logic busy_o,
  output logic done_o
);

  logic   go;
  logic   ser_ready;
  logic   frame_done;
  frame_t frame;

  lcd_cfg_sequencer #(
    .CLKS_PER_US (CLKS_PER_US),
    .PRE_US      (PRE_US)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .on_req_i     (on_req_i),
    .off_req_i    (off_req_i),
    .ser_ready_i  (ser_ready),
    .frame_done_i (frame_done),
    .go_o         (go),
    .frame_o      (frame),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .panel_on_o   (panel_on_o)
  );

  lcd_cfg_serializer #(
    .CLKS_PER_US (CLKS_PER_US),
    .LEAD_US     (LEAD_US),
    .HALF_US     (HALF_US),
    .GAP_US      (GAP_US)
  ) u_ser (
    .clk          (clk),
    .rst          (rst),
    .go_i         (go),
    .frame_i      (frame),
    .ready_o      (ser_ready),
    .frame_done_o (frame_done),
    .sel_n_o      (ser_sel_n_o),
    .sclk_o       (ser_clk_o),
    .sdat_o       (ser_dat_o)
  );

endmodule

// File: rtl/lcd_cfg_seq_chk.sv
module lcd_cfg_seq_chk #(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned HALF_US     = 25,
  parameter int unsigned GAP_US      = 100
) (
  input logic clk,
  input logic rst,
  input logic on_req_i,
  input logic off_req_i,
  input logic ser_sel_n_o,
  input logic ser_clk_o,
  input logic ser_dat_o,
  input logic panel_on_o,
  input logic busy_o,
  input logic done_o
);

  localparam int unsigned HALF_CYC = HALF_US * CLKS_PER_US;
  localparam int unsigned GAP_CYC  = GAP_US * CLKS_PER_US;

  int unsigned lo_cnt;
  int unsigned hi_cnt;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
      seen_q <= 1'b0;
    end else begin
      lo_cnt <= ser_clk_o   ? 0 : lo_cnt + 1;
      hi_cnt <= ser_sel_n_o ? hi_cnt + 1 : 0;
      seen_q <= seen_q | !ser_sel_n_o;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (ser_sel_n_o && ser_clk_o && !ser_dat_o)); // R8
  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_sel_n_o) |-> (ser_clk_o && !ser_dat_o)); // R2
  AST_DAT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!ser_sel_n_o && !$stable(ser_dat_o)) |-> $fell(ser_clk_o)); // R3
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk_o) |-> (lo_cnt == HALF_CYC)); // R3
  AST_GAP_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(ser_sel_n_o) && seen_q) |-> (hi_cnt >= GAP_CYC)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R9
  AST_PANEL_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(panel_on_o) |-> done_o); // R7
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(on_req_i || off_req_i)); // R10

endmodule

bind lcd_cfg_seq lcd_cfg_seq_chk #(
  .CLKS_PER_US (CLKS_PER_US),
  .HALF_US     (HALF_US),
  .GAP_US      (GAP_US)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .on_req_i    (on_req_i),
  .off_req_i   (off_req_i),
  .ser_sel_n_o (ser_sel_n_o),
  .ser_clk_o   (ser_clk_o),
  .ser_dat_o   (ser_dat_o),
  .panel_on_o  (panel_on_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/lcd_cfg_seq_bench.sv
`timescale 1ns/1ps
module lcd_cfg_seq_bench;

  localparam int CPU      = 2;
  localparam int LEAD_CYC = 25 * CPU;
  localparam int HALF_CYC = 25 * CPU;
  localparam int GAP_CYC  = 100 * CPU;
  localparam int PRE_CYC  = 50 * CPU;
  localparam int LIMIT    = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on_req = 1'b0;
  logic off_req = 1'b0;
  logic sel_n, sclk, sdat, panel_on, busy, done;

  always #10 clk = ~clk;

  lcd_cfg_seq #(.CLKS_PER_US(CPU)) u_lcd_cfg_seq (
    .clk         (clk),
    .rst         (rst),
    .on_req_i    (on_req),
    .off_req_i   (off_req),
    .ser_sel_n_o (sel_n),
    .ser_clk_o   (sclk),
    .ser_dat_o   (sdat),
    .panel_on_o  (panel_on),
    .busy_o      (busy),
    .done_o      (done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t_req = 0;
  bit pre_chk = 0;
  int nframes = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Monitor: decodes frames from the pins and scores them against the queue.
  logic p_sel = 1'b1, p_sclk = 1'b1;
  int t_sel = 0, t_fall = 0, t_rise = 0, t_up = 0, nbits = 0;
  bit first = 0, seen = 0;
  logic [15:0] shreg = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_sel && !sel_n) begin
        chk(sclk && !sdat, "R2 select falls with clk high, data low", {sclk, sdat}, 2'b10);
        if (seen) chk(cyc - t_up >= GAP_CYC, "R4 gap before frame", cyc - t_up, GAP_CYC);
        if (pre_chk) begin
          chk(cyc - t_req >= PRE_CYC, "R5 power-up lead wait", cyc - t_req, PRE_CYC);
          pre_chk = 0;
        end
        t_sel = cyc; nbits = 0; first = 1; shreg = '0;
      end
      if (!sel_n && p_sclk && !sclk) begin
        if (first) chk(cyc - t_sel == LEAD_CYC, "R2 select to first clock fall", cyc - t_sel, LEAD_CYC);
        else       chk(cyc - t_rise == HALF_CYC, "R3 clock high time", cyc - t_rise, HALF_CYC);
        first = 0; t_fall = cyc;
      end
      if (!sel_n && !p_sclk && sclk) begin
        chk(cyc - t_fall == HALF_CYC, "R3 clock low time", cyc - t_fall, HALF_CYC);
        shreg = {shreg[14:0], sdat};
        nbits++; t_rise = cyc;
      end
      if (!p_sel && sel_n) begin
        nframes++;
        chk(nbits == 16, "R1 bits per frame", nbits, 16);
        chk(cyc - t_rise == HALF_CYC, "R4 last rise to select high", cyc - t_rise, HALF_CYC);
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected frame", shreg, 0);
        end else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(shreg == e, {"R1 frame content ", t}, shreg, e);
        end
        t_up = cyc; seen = 1;
      end
      p_sel = sel_n; p_sclk = sclk;
    end
  end

  task automatic pulse(input logic on, input logic off);
    @(negedge clk);
    on_req = on; off_req = off; t_req = cyc;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic push_up();
    logic [15:0] tbl [9] = '{16'h0516, 16'h040b, 16'h078d, 16'h0195,
                             16'h08c0, 16'h0340, 16'h0675, 16'h1301, 16'h0557};
    foreach (tbl[i]) begin
      exp_q.push_back(tbl[i]);
      tag_q.push_back("R5");
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cyc > LIMIT);
    chk(0, "watchdog", cyc, LIMIT);
    finish_run();
  end

  initial begin
    int nf;
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(sel_n && sclk && !sdat, "R8 pins in reset", {sel_n, sclk, sdat}, 3'b110);
    chk(!busy && !done && !panel_on, "R8 flags in reset", {busy, done, panel_on}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_n && sclk && !sdat && !busy, "R8 idle after reset", {sel_n, sclk, sdat, busy}, 4'b1100);

    // Power-up table, with stray requests while busy (R10)
    push_up();
    pre_chk = 1;
    pulse(1'b1, 1'b0);
    chk(busy, "R9 busy after accept", busy, 1);
    chk(panel_on, "R7 panel enable before frames", panel_on, 1);
    chk(sel_n, "R5 no frame yet", sel_n, 1);
    repeat (300) @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (500) @(negedge clk);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    wait_done();
    chk(!busy, "R9 busy low with done", busy, 0);
    chk(panel_on, "R7 panel stays on after power-up", panel_on, 1);
    chk(exp_q.size() == 0, "R5 all power-up frames seen", exp_q.size(), 0);
    chk(nframes == 9, "R10 frame count after stray requests", nframes, 9);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (400) @(negedge clk);
    chk(sel_n && !busy, "R10 no restart after ignored requests", {sel_n, busy}, 2'b10);

    // Shutdown table
    exp_q.push_back(16'h055e); tag_q.push_back("R6");
    pulse(1'b0, 1'b1);
    chk(busy, "R9 busy on shutdown", busy, 1);
    do @(negedge clk); while (sel_n);
    do @(negedge clk); while (!sel_n);
    chk(panel_on, "R7 panel still on after shutdown frame", panel_on, 1);
    wait_done();
    chk(!panel_on, "R7 panel off at done", panel_on, 0);
    chk(exp_q.size() == 0, "R6 shutdown frame seen", exp_q.size(), 0);

    // Same-cycle collision: shutdown wins (R11)
    nf = nframes;
    exp_q.push_back(16'h055e); tag_q.push_back("R11");
    pulse(1'b1, 1'b1);
    chk(busy && !panel_on, "R11 shutdown taken on collision", {busy, panel_on}, 2'b10);
    wait_done();
    chk(nframes == nf + 1, "R11 single frame on collision", nframes - nf, 1);
    chk(!panel_on, "R11 panel stays off", panel_on, 0);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0 && sel_n, "R11 no power-up after collision", exp_q.size(), 0);

    finish_run();
  end

endmodule